// File: doc/BRIEF.md
# FM DDS Frequency-Word Sequencer

This block drives audio frequency modulation of a synthesizer that is loaded over a serial link and commits its new tuning word on a separate latch line. A free-running sample timer divides the system clock down to the audio sample rate. On every sample edge the block raises the latch line, which commits the word loaded during the previous period, and sends a one-cycle conversion request to an external ADC.

When the ADC reports a finished conversion, the 12-bit offset-binary reading becomes a signed audio value. The block then forms the 32-bit phase increment for the carrier plus the scaled deviation in fixed point. It drops the latch line and shifts a 40-bit frame out on a mode-0 serial clock. The latch stays low after the last bit, so every frequency change lands exactly on a timer edge and is not tied to the end of the transfer. The block also keeps a running minimum and maximum of the audio value, which can be cleared. A sticky flag records any sample period whose update had to be dropped.

Top module: `fmdds_seq`

## Requirements
- R1: The conversion request `adc_start` pulses for one cycle every CLK_HZ/TICK_HZ clock cycles (2500 cycles at the 100 MHz / 40 kHz defaults; 20 kHz gives 5000). The first pulse comes CLK_HZ/TICK_HZ+1 cycles after reset is released.
- R2: The latch output `dds_latch` resets high. When it goes high after a transfer, it does so in the same cycle as an `adc_start` pulse.
- R3: A raw reading is turned into audio = raw - 2048. A raw value of 2048 therefore gives a word equal to the bare carrier word.
- R4: The phase word is floor((CARRIER_HZ*2048 + audio*DEV_HZ) * K / 2^35) mod 2^32, where K = floor(2^56 / DDS_CLK_HZ) is the unsigned Q8.24 counts-per-hertz constant.
- R5: Each frame is 40 bits, sent most significant bit first. The first 8 bits are a control byte of zero, and the next 32 bits are the phase word from bit 31 down to bit 0.
- R6: `dds_latch` goes low no later than the cycle in which the first bit is presented. It stays low while bits are shifted and after the last bit until the next sample edge.
- R7: `dds_sck` idles low. Data changes only on its falling edge and is held while it is high. Consecutive rising edges are 2*floor(CLK_HZ/(2*SCK_HZ)) clock cycles apart (12 cycles by default).
- R8: `audio_min` and `audio_max` reset to +2047 and -2048 and track every reported sample. A `minmax_clr` pulse returns them to those reset values, and the clear takes priority over a sample arriving in the same cycle.
- R9: If a sample edge arrives while a word is being computed or shifted, `overrun` becomes 1 and stays 1 until reset. `dds_latch` stays low at that edge and rises at the next sample edge that finds the link idle.
- R10: A conversion-done pulse that arrives while a word is being computed or shifted sets `overrun` and produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_start | output | 1 | One-cycle conversion request to the ADC |
| adc_done | input | 1 | One-cycle conversion-finished strobe |
| adc_data | input | 12 | Offset-binary ADC reading, valid with adc_done |
| dds_sck | output | 1 | Serial clock, mode 0 |
| dds_mosi | output | 1 | Serial data, MSB first |
| dds_latch | output | 1 | Frequency commit line; rising edge commits the loaded word |
| minmax_clr | input | 1 | Returns the min/max trackers to their reset values |
| audio_min | output | 12 | Smallest signed audio value since the last clear |
| audio_max | output | 12 | Largest signed audio value since the last clear |
| overrun | output | 1 | Sticky flag for a dropped update |

## Verification
The assertions assume that `adc_done` is a single-cycle strobe and that the configured carrier is larger than the deviation, so the frequency sum never goes negative. They also assume the sample period is longer than two clock cycles. The behavioural ADC in the bench meets these conditions. It answers each conversion request with one strobe after a scripted delay, and the only extra strobes and late answers it sends are those injected on purpose to exercise the two overrun cases.

// File: rtl/fmdds_pkg.sv
package fmdds_pkg;

    localparam int SAMPLE_W = 12;
    localparam int WORD_W   = 32;
    localparam int CTRL_W   = 8;
    localparam int FRAME_W  = CTRL_W + WORD_W;
    localparam int CPH_FRAC = 24;

    typedef logic signed [SAMPLE_W-1:0] audio_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [WORD_W-1:0] dphase;
    } dds_frame_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } sh_state_e;

    // offset binary to two's complement: subtract mid-scale
    function automatic audio_t to_audio(input logic [SAMPLE_W-1:0] raw);
        return audio_t'({~raw[SAMPLE_W-1], raw[SAMPLE_W-2:0]});
    endfunction

endpackage

// File: rtl/fmdds_tick_gen.sv
module fmdds_tick_gen #(
    parameter int DIV = 2500
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/fmdds_word_calc.sv
module fmdds_word_calc
    import fmdds_pkg::*;
#(
    parameter longint unsigned DDS_CLK_HZ = 180_000_000,
    parameter longint unsigned CARRIER_HZ = 20_000_000,
    parameter longint unsigned DEV_HZ     = 5_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_raw,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word
);
    localparam int FREQ_W   = 48;
    localparam int PROD_W   = FREQ_W + WORD_W;
    localparam int SCALE_SH = (SAMPLE_W - 1) + CPH_FRAC;
    localparam logic [63:0] K_FULL = (64'd1 << (WORD_W + CPH_FRAC)) / 64'(DDS_CLK_HZ);
    localparam logic [WORD_W-1:0] K_Q824 = WORD_W'(K_FULL);

    audio_t                    audio;
    logic signed [FREQ_W-1:0]  aud_x;
    logic signed [FREQ_W-1:0]  car_x;
    logic signed [FREQ_W-1:0]  dev_x;
    logic signed [FREQ_W-1:0]  freq_q;
    logic        [PROD_W-1:0]  prod;
    logic        [WORD_W-1:0]  word;

    always_comb begin
        audio  = to_audio(in_raw);
        aud_x  = audio;
        car_x  = FREQ_W'(CARRIER_HZ) <<< (SAMPLE_W - 1);
        dev_x  = FREQ_W'(DEV_HZ);
        freq_q = car_x + aud_x * dev_x;
        prod   = PROD_W'($unsigned(freq_q)) * PROD_W'(K_Q824);
        word   = WORD_W'(prod >> SCALE_SH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= word;
        end
    end

    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: rtl/fmdds_shifter.sv
module fmdds_shifter
    import fmdds_pkg::*;
#(
    parameter int HALF = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  dds_frame_t frame,
    output logic       busy,
    output logic       sck,
    output logic       mosi
);
    localparam int HW = $clog2(HALF + 1);
    localparam int BW = $clog2(FRAME_W);

    sh_state_e            state;
    logic [FRAME_W-1:0]   shreg;
    logic [HW-1:0]        hcnt;
    logic [BW-1:0]        bits;

    assign busy = (state != SH_IDLE);
    assign mosi = shreg[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            shreg <= '0;
            hcnt  <= '0;
            bits  <= '0;
            sck   <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    if (start) begin
                        shreg <= frame;
                        hcnt  <= '0;
                        bits  <= '0;
                        state <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (hcnt == HW'(HALF - 1)) begin
                        hcnt  <= '0;
                        sck   <= 1'b1;
                        state <= SH_HIGH;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (hcnt == HW'(HALF - 1)) begin
                        hcnt <= '0;
                        sck  <= 1'b0;
                        if (bits == BW'(FRAME_W - 1)) begin
                            state <= SH_IDLE;
                        end else begin
                            bits  <= bits + 1'b1;
                            shreg <= shreg << 1;
                            state <= SH_LOW;
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    p_sck_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    p_start_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/fmdds_seq.sv
module fmdds_seq
    import fmdds_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 100_000_000,
    parameter longint unsigned TICK_HZ    = 40_000,
    parameter longint unsigned SCK_HZ     = 8_000_000,
    parameter longint unsigned DDS_CLK_HZ = 180_000_000,
    parameter longint unsigned CARRIER_HZ = 20_000_000,
    parameter longint unsigned DEV_HZ     = 5_000
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       adc_start,
    input  logic                       adc_done,
    input  logic [SAMPLE_W-1:0]        adc_data,
    output logic                       dds_sck,
    output logic                       dds_mosi,
    output logic                       dds_latch,
    input  logic                       minmax_clr,
    output logic signed [SAMPLE_W-1:0] audio_min,
    output logic signed [SAMPLE_W-1:0] audio_max,
    output logic                       overrun
);
    localparam int TICK_DIV = int'(CLK_HZ / TICK_HZ);
    localparam int SCK_HALF = (CLK_HZ / (2 * SCK_HZ)) < 1 ? 1 : int'(CLK_HZ / (2 * SCK_HZ));
    localparam audio_t AUD_TOP = audio_t'({1'b0, {(SAMPLE_W-1){1'b1}}});
    localparam audio_t AUD_BOT = audio_t'({1'b1, {(SAMPLE_W-1){1'b0}}});

    logic              tick;
    logic              calc_valid;
    logic [WORD_W-1:0] calc_word;
    logic              sh_busy;
    logic              link_busy;
    logic              accept;
    dds_frame_t        frame;
    audio_t            audio_now;

    assign link_busy = sh_busy | calc_valid;
    assign accept    = adc_done & ~link_busy;
    assign audio_now = to_audio(adc_data);

    always_comb begin
        frame.ctrl   = '0;
        frame.dphase = calc_word;
    end

    fmdds_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fmdds_word_calc #(
        .DDS_CLK_HZ (DDS_CLK_HZ),
        .CARRIER_HZ (CARRIER_HZ),
        .DEV_HZ     (DEV_HZ)
    ) u_calc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (accept),
        .in_raw    (adc_data),
        .out_valid (calc_valid),
        .out_word  (calc_word)
    );

    fmdds_shifter #(.HALF(SCK_HALF)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (calc_valid),
        .frame (frame),
        .busy  (sh_busy),
        .sck   (dds_sck),
        .mosi  (dds_mosi)
    );

    // sample-edge sequencing: conversion request, latch commit, overrun
    always_ff @(posedge clk) begin
        if (rst) begin
            adc_start <= 1'b0;
            dds_latch <= 1'b1;
            overrun   <= 1'b0;
        end else begin
            adc_start <= tick;
            if (tick) begin
                if (link_busy) overrun   <= 1'b1;
                else           dds_latch <= 1'b1;
            end
            if (adc_done && link_busy) overrun <= 1'b1;
            if (calc_valid) dds_latch <= 1'b0;
        end
    end

    // running extremes of the signed audio value
    always_ff @(posedge clk) begin
        if (rst || minmax_clr) begin
            audio_min <= AUD_TOP;
            audio_max <= AUD_BOT;
        end else if (adc_done) begin
            if (audio_now < audio_min) audio_min <= audio_now;
            if (audio_now > audio_max) audio_max <= audio_now;
        end
    end

    p_latch_rise_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(dds_latch) |-> adc_start);

    p_latch_low_shift_r6: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> !dds_latch);

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    p_busy_edge_holds_latch_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && sh_busy) |=> !dds_latch);

endmodule

// File: tb/tb_fmdds_seq.sv
module tb_fmdds_seq;

    localparam int         TICK_CYC = 2500;
    localparam int         SCK_CYC  = 12;
    localparam logic [79:0] K_REF   = (80'd1 << 56) / 80'd180_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_start;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;
    logic        dds_sck;
    logic        dds_mosi;
    logic        dds_latch;
    logic        minmax_clr = 1'b0;
    logic signed [11:0] audio_min;
    logic signed [11:0] audio_max;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [39:0] exp_q[$];
    int frames = 0;

    always #5 clk = ~clk;

    fmdds_seq dut (
        .clk        (clk),
        .rst        (rst),
        .adc_start  (adc_start),
        .adc_done   (adc_done),
        .adc_data   (adc_data),
        .dds_sck    (dds_sck),
        .dds_mosi   (dds_mosi),
        .dds_latch  (dds_latch),
        .minmax_clr (minmax_clr),
        .audio_min  (audio_min),
        .audio_max  (audio_max),
        .overrun    (overrun)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(input logic [11:0] raw);
        longint      aud  = longint'(raw) - 2048;
        longint      fsum = 64'd20_000_000 * 2048 + aud * 5000;
        logic [79:0] p    = 80'(fsum) * K_REF;
        return p[66:35];
    endfunction

    task automatic wait_start();
        do @(negedge clk); while (!adc_start);
    endtask

    task automatic pulse_done(input logic [11:0] raw, input bit expect_frame);
        adc_done = 1'b1;
        adc_data = raw;
        if (expect_frame) exp_q.push_back({8'h00, ref_word(raw)});
        @(negedge clk);
        adc_done = 1'b0;
    endtask

    task automatic serve(input logic [11:0] raw, input int delay);
        wait_start();
        repeat (delay) @(negedge clk);
        pulse_done(raw, 1'b1);
    endtask

    // monitor: frame capture, scoreboard compare, timing of ticks and clocks
    logic [39:0] rx;
    int  nbits = 0;
    bit  prev_sck = 0;
    bit  prev_latch = 1;
    longint cyc = 0;
    longint last_rise = -1;
    longint last_start = -1;
    bit  period_ok = 1;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            nbits = 0;
            last_start = -1;
            prev_sck = 0;
            prev_latch = 1;
        end else begin
            if (adc_start) begin
                if (last_start >= 0)
                    chk(cyc - last_start == TICK_CYC, "R1 tick period", cyc - last_start, TICK_CYC);
                last_start = cyc;
            end
            if (dds_latch && !prev_latch)
                chk(adc_start == 1'b1, "R2 latch rise with start", adc_start, 1);
            if (dds_sck && !prev_sck) begin
                if (nbits > 0 && cyc - last_rise != SCK_CYC) period_ok = 0;
                last_rise = cyc;
                rx = {rx[38:0], dds_mosi};
                nbits++;
                if (nbits == 40) begin
                    nbits = 0;
                    frames++;
                    chk(period_ok, "R7 sck period", period_ok, 1);
                    period_ok = 1;
                    chk(dds_latch == 1'b0, "R6 latch low after last bit", dds_latch, 0);
                    chk(rx[39:32] == 8'h00, "R5 control byte", rx[39:32], 0);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10 unexpected frame", rx[31:0], 0);
                    end else begin
                        logic [39:0] e;
                        e = exp_q.pop_front();
                        if (e[31:0] == ref_word(12'd2048))
                            chk(rx == e, "R3 zero offset word", rx[31:0], e[31:0]);
                        else
                            chk(rx == e, "R4 frame word", rx[31:0], e[31:0]);
                    end
                end
            end
            prev_sck = dds_sck;
            prev_latch = dds_latch;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        chk(dds_latch == 1'b1, "R2 reset latch", dds_latch, 1);
        chk(dds_sck == 1'b0, "R7 reset sck", dds_sck, 0);
        chk(adc_start == 1'b0, "R1 reset start", adc_start, 0);
        chk(overrun == 1'b0, "R9 reset overrun", overrun, 0);
        chk(audio_min == 12'sd2047, "R8 reset min", audio_min, 2047);
        chk(audio_max == -12'sd2048, "R8 reset max", audio_max, -2048);
        rst = 1'b0;

        serve(12'd2048, 50);
        serve(12'd0, 50);
        serve(12'd4095, 80);
        serve(12'd2047, 50);
        repeat (700) @(negedge clk);
        chk(audio_min == -12'sd2048, "R8 min", audio_min, -2048);
        chk(audio_max == 12'sd2047, "R8 max", audio_max, 2047);
        minmax_clr = 1'b1;
        @(negedge clk);
        minmax_clr = 1'b0;
        chk(audio_min == 12'sd2047, "R8 clear min", audio_min, 2047);
        chk(audio_max == -12'sd2048, "R8 clear max", audio_max, -2048);
        serve(12'd1000, 50);
        serve(12'd3000, 50);
        repeat (700) @(negedge clk);
        chk(audio_min == -12'sd1048, "R8 min after clear", audio_min, -1048);
        chk(audio_max == 12'sd952, "R8 max after clear", audio_max, 952);
        chk(overrun == 1'b0, "R9 no overrun in normal flow", overrun, 0);

        // R10: second done while the first frame is still shifting
        f0 = frames;
        serve(12'd500, 50);
        repeat (100) @(negedge clk);
        pulse_done(12'd100, 1'b0);
        chk(overrun == 1'b1, "R10 overrun on busy done", overrun, 1);
        repeat (700) @(negedge clk);
        chk(frames == f0 + 1, "R10 single frame", frames, f0 + 1);
        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R9 overrun cleared by reset", overrun, 0);

        // R9: late conversion makes the next sample edge find the link busy
        serve(12'd1500, 2450);
        wait_start();
        chk(dds_latch == 1'b0, "R9 latch held at busy edge", dds_latch, 0);
        chk(overrun == 1'b1, "R9 overrun on busy edge", overrun, 1);
        repeat (599) @(negedge clk);
        pulse_done(12'd2500, 1'b1);
        wait_start();
        chk(dds_latch == 1'b1, "R9 latch at next idle edge", dds_latch, 1);
        chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
        repeat (700) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule